// File: doc/BRIEF.md
# Device Error Classifier and Signaler

This block sits beside the error detectors of a serial-link endpoint function. Every detected error reaches it as one event carrying a status vector, a flag that marks the event as correctable, a flag that allows a non-fatal error to be downgraded to an advisory one, and a 16-bit requester identity. From copies of the function's configuration bits (system-error enable, the four reporting enables in device control, and the error mask and severity registers) the block decides what to record and what to report. It sets the sticky device status bits and the correctable and uncorrectable error status vectors. It also asks an external header store to capture the offending request and emits at most one error message per event, tagged with a severity class and the identity.

An event is accepted in any cycle where the ready output is high. Its results (status updates, message pulse, capture request) appear one clock later. The header store answers a capture request with an overflow flag in the same cycle as the request. When that flag is raised, the block drops ready for two cycles and then runs a correctable header-log-overflow error of its own through the same decision logic. The controller has two states. ST_IDLE accepts external events and takes transition T_OVF to ST_HLO when an overflow is reported. ST_HLO processes the internal overflow error and always takes transition T_DONE back to ST_IDLE.

Top module: `dev_err_signaler`

## Requirements
- R1: The status vector is first reduced to the supported bits of its class: uncorrectable bits 4, 5 and 12 to 25, correctable bits 0, 6, 7, 8 and 12 to 15. If the result does not have exactly one bit set, the event is dropped, with no status change, no capture request and no message.
- R2: An uncorrectable error is fatal by default for bits 4, 5, 13, 17, 18 and 22 and non-fatal for the other supported bits. While cfg_sev_prog_i is high, the matching bit of cfg_unc_sev_i decides instead (1 = fatal). The message severity code is 01 correctable, 10 non-fatal, 11 fatal.
- R3: A correctable event sets dev_sta_o[0] and its bit of cor_sta_o. It sends a correctable message only when its bit of cfg_cor_mask_i is clear and cfg_cor_rep_en_i is high.
- R4: A non-fatal event with the advisory flag sets dev_sta_o[0] and cor_sta_o[13]. If cor mask bit 13 is set, nothing else happens. Otherwise its uncorrectable status bit is set, a capture is requested only if its uncorrectable mask bit is clear, and a correctable message follows the R3 and R6 enables.
- R5: An uncorrectable error whose bit of cfg_unc_mask_i is set still sets its status bit and its dev_sta_o bit, but requests no capture and sends no message. An unmasked one always requests a capture of its one-hot bit.
- R6: The unsupported-request error (uncorrectable bit 20) also sets dev_sta_o[3]. It sends no message when both cfg_ur_rep_en_i and cfg_serr_en_i are low (for the advisory path: when cfg_ur_rep_en_i is low). A non-advisory fatal error sets dev_sta_o[2] and a non-fatal one sets dev_sta_o[1].
- R7: An unmasked fatal error is reported when cfg_serr_en_i or cfg_fat_rep_en_i is high. An unmasked non-fatal error is reported when cfg_serr_en_i or cfg_nf_rep_en_i is high.
- R8: When log_ovf_i is high together with log_req_o, the original message has already been emitted. Two cycles later the block applies a correctable error at bit 15 with the logged event's identity, following the R3 rules.
- R9: dev_sta_o, unc_sta_o and cor_sta_o bits never clear except through reset, and all are zero after reset.
- R10: Message and capture outputs are registered: they appear the cycle after acceptance and last one cycle, and log_status_o is one-hot whenever log_req_o is high.
- R11: evt_ready_o is high in ST_IDLE unless log_req_o and log_ovf_i are both high, and low in ST_HLO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_valid_i | input | 1 | Error event present |
| evt_ready_o | output | 1 | Event accepted this cycle when high |
| evt_status_i | input | 32 | Error status vector |
| evt_is_corr_i | input | 1 | Event belongs to the correctable class |
| evt_maybe_adv_i | input | 1 | Non-fatal event may be downgraded to advisory |
| evt_src_i | input | 16 | Requester identity |
| cfg_serr_en_i | input | 1 | System-error enable from the command register |
| cfg_cor_rep_en_i | input | 1 | Correctable reporting enable |
| cfg_nf_rep_en_i | input | 1 | Non-fatal reporting enable |
| cfg_fat_rep_en_i | input | 1 | Fatal reporting enable |
| cfg_ur_rep_en_i | input | 1 | Unsupported-request reporting enable |
| cfg_sev_prog_i | input | 1 | Use programmed severity instead of defaults |
| cfg_unc_sev_i | input | 32 | Programmed uncorrectable severity, 1 = fatal |
| cfg_unc_mask_i | input | 32 | Uncorrectable error mask |
| cfg_cor_mask_i | input | 32 | Correctable error mask |
| msg_valid_o | output | 1 | Error message pulse |
| msg_sev_o | output | 2 | Message severity code |
| msg_src_o | output | 16 | Message requester identity |
| log_req_o | output | 1 | Header capture request pulse |
| log_status_o | output | 32 | One-hot uncorrectable bit being captured |
| log_src_o | output | 16 | Identity of the captured event |
| log_ovf_i | input | 1 | Header store overflow, valid with log_req_o |
| dev_sta_o | output | 4 | Device status: 0 correctable, 1 non-fatal, 2 fatal, 3 unsupported request |
| unc_sta_o | output | 32 | Uncorrectable error status |
| cor_sta_o | output | 32 | Correctable error status |

## Verification
The hardest situation to reach is the overflow follow-up. It needs an unmasked uncorrectable event that requests a capture, with the store answering overflow in exactly the cycle the request is visible. The stall, the follow-up error and its message must then be observed two cycles later. The bench holds log_ovf_i high across a directed non-fatal event, releases it after the request, and repeats the sequence with the follow-up both reportable and masked. All other paths are covered by a sweep of every status bit against every combination of the enable, mask, severity-override and advisory inputs, followed by a sweep of all two-bit vectors in both classes.

// File: rtl/des_pkg.sv
package des_pkg;

    localparam int STA_W  = 32;
    localparam int DSTA_W = 4;

    // supported and default-fatal bit sets
    localparam logic [STA_W-1:0] UNC_SUP        = 32'h03FF_F030;
    localparam logic [STA_W-1:0] COR_SUP        = 32'h0000_F1C1;
    localparam logic [STA_W-1:0] UNC_DFLT_FATAL = 32'h0046_2030;

    localparam int UR_BIT  = 20;
    localparam int ADV_BIT = 13;
    localparam int HLO_BIT = 15;

    localparam logic [STA_W-1:0] ADV_VEC = STA_W'(1) << ADV_BIT;
    localparam logic [STA_W-1:0] HLO_VEC = STA_W'(1) << HLO_BIT;

    // device status bit positions
    localparam int DS_CED  = 0;
    localparam int DS_NFED = 1;
    localparam int DS_FED  = 2;
    localparam int DS_URD  = 3;

    typedef enum logic [1:0] {
        SEV_NONE     = 2'b00,
        SEV_COR      = 2'b01,
        SEV_NONFATAL = 2'b10,
        SEV_FATAL    = 2'b11
    } sev_e;

    typedef struct packed {
        logic              accept;
        logic [DSTA_W-1:0] dsta_set;
        logic [STA_W-1:0]  unc_set;
        logic [STA_W-1:0]  cor_set;
        logic              log_req;
        logic [STA_W-1:0]  log_bit;
        logic              msg_send;
        sev_e              sev;
    } verdict_t;

endpackage

// File: rtl/des_classify.sv
module des_classify
    import des_pkg::*;
(
    input  logic             ev_valid,
    input  logic [STA_W-1:0] ev_status,
    input  logic             ev_is_corr,
    input  logic             ev_maybe_adv,
    input  logic             serr_en,
    input  logic             cor_rep_en,
    input  logic             nf_rep_en,
    input  logic             fat_rep_en,
    input  logic             ur_rep_en,
    input  logic             sev_prog,
    input  logic [STA_W-1:0] unc_sev,
    input  logic [STA_W-1:0] unc_mask,
    input  logic [STA_W-1:0] cor_mask,
    output verdict_t         verdict
);

    logic [STA_W-1:0] hit;
    logic [STA_W-1:0] sev_tab;
    logic [STA_W-1:0] cor_bit;
    logic             single;
    logic             is_ur;
    logic             fatal;
    logic             as_cor;
    logic             unc_masked;
    logic             cor_masked;

    always_comb begin
        hit        = ev_status & (ev_is_corr ? COR_SUP : UNC_SUP);
        single     = (hit != '0) && ((hit & (hit - STA_W'(1))) == '0);
        is_ur      = !ev_is_corr && hit[UR_BIT];
        sev_tab    = sev_prog ? unc_sev : UNC_DFLT_FATAL;
        fatal      = !ev_is_corr && (|(hit & sev_tab));
        as_cor     = ev_is_corr || (!fatal && ev_maybe_adv);
        cor_bit    = ev_is_corr ? hit : ADV_VEC;
        unc_masked = |(hit & unc_mask);
        cor_masked = |(cor_bit & cor_mask);
    end

    always_comb begin
        verdict = '0;
        verdict.sev = SEV_NONE;
        if (ev_valid && single) begin
            verdict.accept = 1'b1;
            if (is_ur) begin
                verdict.dsta_set[DS_URD] = 1'b1;
            end
            if (as_cor) begin
                verdict.dsta_set[DS_CED] = 1'b1;
                verdict.cor_set          = cor_bit;
                if (!cor_masked) begin
                    if (!ev_is_corr) begin
                        verdict.unc_set = hit;
                        if (!unc_masked) begin
                            verdict.log_req = 1'b1;
                            verdict.log_bit = hit;
                        end
                    end
                    if (cor_rep_en && !(is_ur && !ur_rep_en)) begin
                        verdict.msg_send = 1'b1;
                        verdict.sev      = SEV_COR;
                    end
                end
            end else begin
                if (fatal) begin
                    verdict.dsta_set[DS_FED] = 1'b1;
                end else begin
                    verdict.dsta_set[DS_NFED] = 1'b1;
                end
                verdict.unc_set = hit;
                if (!unc_masked) begin
                    verdict.log_req = 1'b1;
                    verdict.log_bit = hit;
                    if (!(is_ur && !ur_rep_en && !serr_en)) begin
                        if (fatal && (serr_en || fat_rep_en)) begin
                            verdict.msg_send = 1'b1;
                            verdict.sev      = SEV_FATAL;
                        end else if (!fatal && (serr_en || nf_rep_en)) begin
                            verdict.msg_send = 1'b1;
                            verdict.sev      = SEV_NONFATAL;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/des_status_store.sv
module des_status_store
    import des_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  verdict_t          verdict,
    output logic [DSTA_W-1:0] dev_sta,
    output logic [STA_W-1:0]  unc_sta,
    output logic [STA_W-1:0]  cor_sta
);

    // each status bit is an independent sticky flop
    for (genvar gi = 0; gi < STA_W; gi++) begin : g_sta
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                unc_sta[gi] <= 1'b0;
                cor_sta[gi] <= 1'b0;
            end else if (verdict.accept) begin
                unc_sta[gi] <= unc_sta[gi] | verdict.unc_set[gi];
                cor_sta[gi] <= cor_sta[gi] | verdict.cor_set[gi];
            end
        end
    end

    for (genvar gd = 0; gd < DSTA_W; gd++) begin : g_dsta
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                dev_sta[gd] <= 1'b0;
            end else if (verdict.accept) begin
                dev_sta[gd] <= dev_sta[gd] | verdict.dsta_set[gd];
            end
        end
    end

endmodule

// File: rtl/des_report.sv
module des_report
    import des_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  verdict_t         verdict,
    input  logic [SRC_W-1:0] src,
    output logic             msg_valid,
    output logic [1:0]       msg_sev,
    output logic [SRC_W-1:0] msg_src,
    output logic             log_req,
    output logic [STA_W-1:0] log_status,
    output logic [SRC_W-1:0] log_src
);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            msg_valid  <= 1'b0;
            msg_sev    <= SEV_NONE;
            msg_src    <= '0;
            log_req    <= 1'b0;
            log_status <= '0;
            log_src    <= '0;
        end else begin
            msg_valid <= verdict.msg_send;
            log_req   <= verdict.log_req;
            if (verdict.msg_send) begin
                msg_sev <= verdict.sev;
                msg_src <= src;
            end else begin
                msg_sev <= SEV_NONE;
            end
            if (verdict.log_req) begin
                log_status <= verdict.log_bit;
                log_src    <= src;
            end
        end
    end

endmodule

// File: rtl/dev_err_signaler.sv
module dev_err_signaler
    import des_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               evt_valid_i,
    output logic               evt_ready_o,
    input  logic [STA_W-1:0]   evt_status_i,
    input  logic               evt_is_corr_i,
    input  logic               evt_maybe_adv_i,
    input  logic [SRC_W-1:0]   evt_src_i,
    input  logic               cfg_serr_en_i,
    input  logic               cfg_cor_rep_en_i,
    input  logic               cfg_nf_rep_en_i,
    input  logic               cfg_fat_rep_en_i,
    input  logic               cfg_ur_rep_en_i,
    input  logic               cfg_sev_prog_i,
    input  logic [STA_W-1:0]   cfg_unc_sev_i,
    input  logic [STA_W-1:0]   cfg_unc_mask_i,
    input  logic [STA_W-1:0]   cfg_cor_mask_i,
    output logic               msg_valid_o,
    output logic [1:0]         msg_sev_o,
    output logic [SRC_W-1:0]   msg_src_o,
    output logic               log_req_o,
    output logic [STA_W-1:0]   log_status_o,
    output logic [SRC_W-1:0]   log_src_o,
    input  logic               log_ovf_i,
    output logic [DSTA_W-1:0]  dev_sta_o,
    output logic [STA_W-1:0]   unc_sta_o,
    output logic [STA_W-1:0]   cor_sta_o
);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HLO  = 1'b1
    } state_e;

    state_e           state_q;
    state_e           state_d;
    logic [SRC_W-1:0] hlo_src_q;
    logic             ovf_seen;

    logic             cls_valid;
    logic [STA_W-1:0] cls_status;
    logic             cls_corr;
    logic             cls_adv;
    logic [SRC_W-1:0] cls_src;
    verdict_t         verdict;

    assign ovf_seen = log_req_o && log_ovf_i;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_OVF (ST_IDLE -> ST_HLO), T_DONE (ST_HLO -> ST_IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ovf_seen) state_d = ST_HLO;
            ST_HLO:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and classifier source selection
    always_comb begin
        evt_ready_o = 1'b0;
        cls_valid   = 1'b0;
        cls_status  = evt_status_i;
        cls_corr    = evt_is_corr_i;
        cls_adv     = evt_maybe_adv_i;
        cls_src     = evt_src_i;
        unique case (state_q)
            ST_IDLE: begin
                evt_ready_o = !ovf_seen;
                cls_valid   = evt_valid_i && !ovf_seen;
            end
            ST_HLO: begin
                cls_valid  = 1'b1;
                cls_status = HLO_VEC;
                cls_corr   = 1'b1;
                cls_adv    = 1'b0;
                cls_src    = hlo_src_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hlo_src_q <= '0;
        end else if (state_q == ST_IDLE && ovf_seen) begin
            hlo_src_q <= log_src_o;
        end
    end

    des_classify u_classify (
        .ev_valid     (cls_valid),
        .ev_status    (cls_status),
        .ev_is_corr   (cls_corr),
        .ev_maybe_adv (cls_adv),
        .serr_en      (cfg_serr_en_i),
        .cor_rep_en   (cfg_cor_rep_en_i),
        .nf_rep_en    (cfg_nf_rep_en_i),
        .fat_rep_en   (cfg_fat_rep_en_i),
        .ur_rep_en    (cfg_ur_rep_en_i),
        .sev_prog     (cfg_sev_prog_i),
        .unc_sev      (cfg_unc_sev_i),
        .unc_mask     (cfg_unc_mask_i),
        .cor_mask     (cfg_cor_mask_i),
        .verdict      (verdict)
    );

    des_status_store u_status (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .verdict (verdict),
        .dev_sta (dev_sta_o),
        .unc_sta (unc_sta_o),
        .cor_sta (cor_sta_o)
    );

    des_report #(.SRC_W(SRC_W)) u_report (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .verdict    (verdict),
        .src        (cls_src),
        .msg_valid  (msg_valid_o),
        .msg_sev    (msg_sev_o),
        .msg_src    (msg_src_o),
        .log_req    (log_req_o),
        .log_status (log_status_o),
        .log_src    (log_src_o)
    );

endmodule

// File: rtl/des_checker.sv
module des_checker
    import des_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              evt_valid_i,
    input logic              evt_ready_o,
    input logic [STA_W-1:0]  evt_status_i,
    input logic              evt_is_corr_i,
    input logic              evt_maybe_adv_i,
    input logic [STA_W-1:0]  cfg_unc_mask_i,
    input logic [STA_W-1:0]  cfg_cor_mask_i,
    input logic              msg_valid_o,
    input logic [1:0]        msg_sev_o,
    input logic              log_req_o,
    input logic [STA_W-1:0]  log_status_o,
    input logic              log_ovf_i,
    input logic [DSTA_W-1:0] dev_sta_o,
    input logic [STA_W-1:0]  unc_sta_o,
    input logic [STA_W-1:0]  cor_sta_o
);

    logic take;
    assign take = evt_valid_i && evt_ready_o;

    AST_REJECT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take && ($countones(evt_status_i & (evt_is_corr_i ? COR_SUP : UNC_SUP)) != 1)
        |=> !msg_valid_o && !log_req_o && $stable(unc_sta_o) && $stable(cor_sta_o) && $stable(dev_sta_o)); // R1

    AST_COR_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take && evt_is_corr_i && ($countones(evt_status_i & COR_SUP) == 1)
             && (|(evt_status_i & COR_SUP & cfg_cor_mask_i))
        |=> !msg_valid_o); // R3

    AST_COR_SEV_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take && evt_is_corr_i |=> !msg_valid_o || (msg_sev_o == 2'b01)); // R3

    AST_UNC_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take && !evt_is_corr_i && !evt_maybe_adv_i
             && ($countones(evt_status_i & UNC_SUP) == 1)
             && (|(evt_status_i & UNC_SUP & cfg_unc_mask_i))
        |=> !msg_valid_o && !log_req_o && (|(unc_sta_o & evt_status_i & UNC_SUP))); // R5

    AST_OVF_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        log_req_o && log_ovf_i |-> !evt_ready_o); // R11

    AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        log_req_o && log_ovf_i |=> !evt_ready_o && !msg_valid_o); // R8

    AST_OVF_FOLLOWUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        log_req_o && log_ovf_i |=> ##1 cor_sta_o[HLO_BIT] && dev_sta_o[DS_CED]); // R8

    AST_STICKY_UNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (unc_sta_o & $past(unc_sta_o)) == $past(unc_sta_o)); // R9

    AST_STICKY_COR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cor_sta_o & $past(cor_sta_o)) == $past(cor_sta_o))
        && ((dev_sta_o & $past(dev_sta_o)) == $past(dev_sta_o))); // R9

    AST_MSG_SEV_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_valid_o |-> msg_sev_o != 2'b00); // R10

    AST_LOG_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        log_req_o |-> $countones(log_status_o) == 1); // R10

    AST_LOG_IS_UNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        log_req_o |-> (log_status_o & ~UNC_SUP) == '0); // R5

endmodule

bind dev_err_signaler des_checker chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .evt_valid_i     (evt_valid_i),
    .evt_ready_o     (evt_ready_o),
    .evt_status_i    (evt_status_i),
    .evt_is_corr_i   (evt_is_corr_i),
    .evt_maybe_adv_i (evt_maybe_adv_i),
    .cfg_unc_mask_i  (cfg_unc_mask_i),
    .cfg_cor_mask_i  (cfg_cor_mask_i),
    .msg_valid_o     (msg_valid_o),
    .msg_sev_o       (msg_sev_o),
    .log_req_o       (log_req_o),
    .log_status_o    (log_status_o),
    .log_ovf_i       (log_ovf_i),
    .dev_sta_o       (dev_sta_o),
    .unc_sta_o       (unc_sta_o),
    .cor_sta_o       (cor_sta_o)
);

// File: tb/dev_err_signaler_tb_top.sv
module dev_err_signaler_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        evt_valid_i = 1'b0;
    logic        evt_ready_o;
    logic [31:0] evt_status_i = '0;
    logic        evt_is_corr_i = 1'b0;
    logic        evt_maybe_adv_i = 1'b0;
    logic [15:0] evt_src_i = '0;
    logic        c_serr = 1'b0, c_cor_en = 1'b0, c_nf_en = 1'b0, c_fat_en = 1'b0, c_ur_en = 1'b0;
    logic        c_sev_prog = 1'b0;
    logic [31:0] c_unc_sev = '0, c_unc_mask = '0, c_cor_mask = '0;
    logic        msg_valid_o;
    logic [1:0]  msg_sev_o;
    logic [15:0] msg_src_o;
    logic        log_req_o;
    logic [31:0] log_status_o;
    logic [15:0] log_src_o;
    logic        log_ovf_i = 1'b0;
    logic [3:0]  dev_sta_o;
    logic [31:0] unc_sta_o, cor_sta_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0]  exp_ds  = '0;
    logic [31:0] exp_unc = '0;
    logic [31:0] exp_cor = '0;

    always #4 clk_i = ~clk_i;  // 125 MHz

    dev_err_signaler dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .evt_valid_i(evt_valid_i), .evt_ready_o(evt_ready_o),
        .evt_status_i(evt_status_i), .evt_is_corr_i(evt_is_corr_i),
        .evt_maybe_adv_i(evt_maybe_adv_i), .evt_src_i(evt_src_i),
        .cfg_serr_en_i(c_serr), .cfg_cor_rep_en_i(c_cor_en),
        .cfg_nf_rep_en_i(c_nf_en), .cfg_fat_rep_en_i(c_fat_en),
        .cfg_ur_rep_en_i(c_ur_en), .cfg_sev_prog_i(c_sev_prog),
        .cfg_unc_sev_i(c_unc_sev), .cfg_unc_mask_i(c_unc_mask),
        .cfg_cor_mask_i(c_cor_mask),
        .msg_valid_o(msg_valid_o), .msg_sev_o(msg_sev_o), .msg_src_o(msg_src_o),
        .log_req_o(log_req_o), .log_status_o(log_status_o), .log_src_o(log_src_o),
        .log_ovf_i(log_ovf_i),
        .dev_sta_o(dev_sta_o), .unc_sta_o(unc_sta_o), .cor_sta_o(cor_sta_o)
    );

    function automatic bit unc_ok(int k);
        return (k == 4) || (k == 5) || (k >= 12 && k <= 25);
    endfunction

    function automatic bit cor_ok(int k);
        return (k == 0) || (k == 6) || (k == 7) || (k == 8) || (k >= 12 && k <= 15);
    endfunction

    function automatic bit dflt_fatal(int k);
        return (k == 4) || (k == 5) || (k == 13) || (k == 17) || (k == 18) || (k == 22);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic ref_eval(input logic [31:0] st, input logic corr, input logic adv,
                            output logic ok, output logic [3:0] ds, output logic [31:0] us,
                            output logic [31:0] cs, output logic lg, output logic [31:0] lb,
                            output logic mv, output logic [1:0] sv);
        int n;
        int b;
        logic fat, ur, ur_pass;
        n = 0; b = 0;
        for (int k = 0; k < 32; k++) begin
            if (st[k] && (corr ? cor_ok(k) : unc_ok(k))) begin
                n++;
                b = k;
            end
        end
        ok = (n == 1);
        ds = '0; us = '0; cs = '0; lg = 1'b0; lb = '0; mv = 1'b0; sv = 2'b00;
        fat = !corr && (c_sev_prog ? c_unc_sev[b] : dflt_fatal(b));
        ur = !corr && (b == 20);
        if (ok) begin
            if (ur) ds[3] = 1'b1;
            if (corr) begin
                ds[0] = 1'b1;
                cs[b] = 1'b1;
                if (!c_cor_mask[b] && c_cor_en) begin mv = 1'b1; sv = 2'b01; end
            end else if (!fat && adv) begin
                ds[0] = 1'b1;
                cs[13] = 1'b1;
                if (!c_cor_mask[13]) begin
                    us[b] = 1'b1;
                    if (!c_unc_mask[b]) begin lg = 1'b1; lb[b] = 1'b1; end
                    if (c_cor_en && (!ur || c_ur_en)) begin mv = 1'b1; sv = 2'b01; end
                end
            end else begin
                if (fat) ds[2] = 1'b1; else ds[1] = 1'b1;
                us[b] = 1'b1;
                if (!c_unc_mask[b]) begin
                    lg = 1'b1;
                    lb[b] = 1'b1;
                    ur_pass = !ur || c_ur_en || c_serr;
                    mv = ur_pass && (c_serr || (fat ? c_fat_en : c_nf_en));
                    if (mv) sv = fat ? 2'b11 : 2'b10;
                end
            end
        end
    endtask

    // one event, results checked one clock later; tag names the path under test
    task automatic run_ev(input logic [31:0] st, input logic corr, input logic adv,
                          input logic [15:0] src, input string tag);
        logic ok, lg, mv;
        logic [3:0] ds;
        logic [31:0] us, cs, lb;
        logic [1:0] sv;
        @(negedge clk_i);
        evt_valid_i = 1'b1; evt_status_i = st; evt_is_corr_i = corr;
        evt_maybe_adv_i = adv; evt_src_i = src;
        ref_eval(st, corr, adv, ok, ds, us, cs, lg, lb, mv, sv);
        exp_ds = exp_ds | ds; exp_unc = exp_unc | us; exp_cor = exp_cor | cs;
        @(negedge clk_i);
        evt_valid_i = 1'b0;
        chk(ok ? tag : "R1", "msg_valid", {31'b0, msg_valid_o}, {31'b0, mv});
        if (mv) begin
            chk("R2", "msg_sev", {30'b0, msg_sev_o}, {30'b0, sv});
            chk("R10", "msg_src", {16'b0, msg_src_o}, {16'b0, src});
        end
        chk(ok ? "R5" : "R1", "log_req", {31'b0, log_req_o}, {31'b0, lg});
        if (lg) chk("R4", "log_status", log_status_o, lb);
        chk("R9", "unc_sta", unc_sta_o, exp_unc);
        chk("R3", "cor_sta", cor_sta_o, exp_cor);
        chk("R6", "dev_sta", {28'b0, dev_sta_o}, {28'b0, exp_ds});
    endtask

    task automatic ovf_case(input logic cen, input logic m15);
        c_serr = 0; c_nf_en = 1; c_fat_en = 0; c_ur_en = 0; c_sev_prog = 0;
        c_unc_mask = '0; c_cor_en = cen; c_cor_mask = m15 ? 32'h0000_8000 : 32'h0;
        log_ovf_i = 1'b1;
        @(negedge clk_i);
        evt_valid_i = 1'b1; evt_status_i = 32'h0000_1000; evt_is_corr_i = 0;
        evt_maybe_adv_i = 0; evt_src_i = 16'h5A5A;
        @(negedge clk_i);
        evt_valid_i = 1'b0;
        exp_unc[12] = 1'b1; exp_ds[1] = 1'b1;
        chk("R8", "first msg_valid", {31'b0, msg_valid_o}, 32'd1);
        chk("R8", "first msg_sev", {30'b0, msg_sev_o}, 32'd2);
        chk("R5", "log_req", {31'b0, log_req_o}, 32'd1);
        chk("R11", "ready on overflow", {31'b0, evt_ready_o}, 32'd0);
        @(negedge clk_i);
        log_ovf_i = 1'b0;
        chk("R10", "msg pulse width", {31'b0, msg_valid_o}, 32'd0);
        chk("R8", "ready while follow-up", {31'b0, evt_ready_o}, 32'd0);
        @(negedge clk_i);
        exp_cor[15] = 1'b1; exp_ds[0] = 1'b1;
        chk("R8", "follow-up cor_sta", cor_sta_o, exp_cor);
        chk("R8", "follow-up dev_sta", {28'b0, dev_sta_o}, {28'b0, exp_ds});
        chk("R8", "follow-up msg_valid", {31'b0, msg_valid_o}, {31'b0, cen && !m15});
        if (cen && !m15) begin
            chk("R8", "follow-up sev", {30'b0, msg_sev_o}, 32'd1);
            chk("R8", "follow-up src", {16'b0, msg_src_o}, 32'h5A5A);
        end
        chk("R11", "ready after follow-up", {31'b0, evt_ready_o}, 32'd1);
        chk("R9", "unc_sta", unc_sta_o, exp_unc);
    endtask

    initial begin
        repeat (190000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] prog_sev;
        prog_sev = '0;
        for (int k = 0; k < 32; k++) prog_sev[k] = !dflt_fatal(k);
        c_unc_sev = prog_sev;
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R9", "reset unc_sta", unc_sta_o, 32'h0);
        chk("R9", "reset cor_sta", cor_sta_o, 32'h0);
        chk("R9", "reset dev_sta", {28'b0, dev_sta_o}, 32'h0);
        chk("R10", "reset msg_valid", {31'b0, msg_valid_o}, 32'h0);
        chk("R11", "idle ready", {31'b0, evt_ready_o}, 32'd1);

        // correctable sweep
        for (int b = 0; b < 32; b++) begin
            for (int c = 0; c < 4; c++) begin
                c_cor_mask = c[0] ? (32'h1 << b) : 32'h0;
                c_cor_en = c[1];
                run_ev(32'h1 << b, 1'b1, 1'b0, 16'h3000 ^ 16'(b << 4) ^ 16'(c), "R3");
            end
        end

        // uncorrectable sweep over every configuration combination
        for (int b = 0; b < 32; b++) begin
            for (int c = 0; c < 512; c++) begin
                c_sev_prog = c[1];
                c_unc_mask = c[2] ? (32'h1 << b) : 32'h0;
                c_serr = c[3]; c_nf_en = c[4]; c_fat_en = c[5];
                c_ur_en = c[6]; c_cor_en = c[7];
                c_cor_mask = c[8] ? 32'h0000_2000 : 32'h0;
                run_ev(32'h1 << b, 1'b0, c[0], 16'hA000 ^ 16'(b << 9) ^ 16'(c),
                       c[0] ? "R4" : "R7");
            end
        end

        // two-bit vectors in both classes
        c_serr = 1; c_cor_en = 1; c_nf_en = 1; c_fat_en = 1; c_ur_en = 1;
        c_unc_mask = '0; c_cor_mask = '0; c_sev_prog = 0;
        for (int i = 0; i < 32; i++) begin
            for (int j = i + 1; j < 32; j++) begin
                run_ev((32'h1 << i) | (32'h1 << j), 1'b1, 1'b0, 16'(i * 32 + j), "R3");
                run_ev((32'h1 << i) | (32'h1 << j), 1'b0, 1'b0, 16'(i * 32 + j), "R7");
            end
        end
        run_ev(32'h0, 1'b0, 1'b0, 16'h0001, "R1");
        run_ev(32'hFC00_0FCF, 1'b0, 1'b0, 16'h0002, "R1");

        // header store overflow follow-up
        ovf_case(1'b1, 1'b0);
        ovf_case(1'b1, 1'b1);
        ovf_case(1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule